// File: doc/BRIEF.md
# CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending interrupt as a candidate, made up of a valid flag, a 10-bit ID and an 8-bit priority value. The block decides whether that candidate may be signalled. It may be signalled when signalling is enabled, when its priority value lies strictly below the programmed threshold, and when it is not already being serviced. The decision drives one registered request line to the processor.

The processor reaches the block through a small register port with four word addresses. Address 0 is the control word, whose bit 0 is the enable. Address 1 holds the 8-bit priority threshold. Address 2 is the acknowledge register, and reading it has side effects. Address 3 is the end-of-interrupt register, which takes writes only. A read of address 2 returns the ID of the interrupt being taken and marks it in service. The same read sends a one-cycle take pulse back to the distributor, which uses it to clear an edge-latched pending bit. When nothing is eligible, the read returns the reserved ID 1023. Writing an ID to address 3 ends the service of that interrupt.

Every access is accepted in the cycle in which `acc_valid` is high. There is no back-pressure. A read returns its data on `rd_data`, marked by `rd_valid`, one clock later. The processor and the distributor must both accept results in that cycle, because neither result can be stalled.

Top module: `cpu_ack_if`

## Requirements
- R1: After reset, `irq_o`, `rd_valid` and `take_valid` are 0. The enable bit and the threshold both read back as 0, so no interrupt is signalled.
- R2: A read of address 2 while the candidate is eligible returns the candidate ID in `rd_data[9:0]`, with the upper bits 0. An eligible candidate is one that is valid, has an ID below `NUM_SRC`, is enabled, has a priority below the threshold and is not in service.
- R3: A read of address 2 while no candidate is eligible returns 1023 and produces no take pulse. This covers an invalid candidate, one in service, one with an ID at or above `NUM_SRC`, one that is masked, and the case where signalling is disabled.
- R4: A candidate is eligible only when its priority value is strictly below the 8-bit threshold at address 1. A priority equal to the threshold is blocked. With the threshold at 0xF0, priority 0xA0 passes.
- R5: When bit 0 at address 0 is 0, `irq_o` stays low.
- R6: A successful acknowledge pulses `take_valid` with `take_id` equal to the returned ID, in the same cycle as `rd_valid`. The ID then stays in service and is not offered again.
- R7: Writing an in-service ID to address 3, in `acc_wdata[9:0]`, ends its service, so the same candidate can be signalled and taken again.
- R8: Writing an ID to address 3 that is not in service has no effect.
- R9: `irq_o` reflects eligibility one clock after any change of candidate, enable, threshold or in-service state.
- R10: Reads of addresses 0 and 1 return the stored enable bit in bit 0 and the threshold in bits [7:0]. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | Distributor candidate present |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority value (lower is more urgent) |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Word address: 0 control, 1 threshold, 2 acknowledge, 3 end of interrupt |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one clock after a read |
| rd_data | output | 32 | Read data |
| take_valid | output | 1 | One-cycle pulse: an interrupt was acknowledged |
| take_id | output | 10 | ID acknowledged, meaningful with `take_valid` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Every result of this block appears exactly one clock after its cause. The read data and the take pulse follow the read access by one clock. The request line follows a change in candidate, enable, threshold or in-service state by one clock. The bench drives inputs on the falling edge and advances its behavioural model on the rising edge, in the same way the registers do. On the next falling edge it compares the request line, the take pulse and any read data with the model. It adds targeted checks two falling edges after an end-of-interrupt write, which is when the request line must show whether the write took effect.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ID_W     = 10;
  localparam int PRIO_W   = 8;
  localparam int DATA_W   = 32;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam int MAX_REAL_ID = 1020;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_MASK = 2'd1,
    RA_ACK  = 2'd2,
    RA_EOI  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cpuif_regs.sv
module cpuif_regs
  import cpuif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_addr_e         addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic [PRIO_W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else if (wr_en) begin
      if (addr == RA_CTRL) en_q   <= wdata[0];
      if (addr == RA_MASK) mask_q <= wdata[PRIO_W-1:0];
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!en_q && mask_q == '0));
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active
  import cpuif_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [ID_W-1:0]    set_id,
  input  logic               clr_en,
  input  logic [ID_W-1:0]    clr_id,
  input  logic [ID_W-1:0]    probe_id,
  output logic               probe_busy
);
  logic [NUM_SRC-1:0] busy_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        busy_q[i] <= 1'b0;
      else if (set_en && set_id == ID_W'(i))
        busy_q[i] <= 1'b1;
      else if (clr_en && clr_id == ID_W'(i))
        busy_q[i] <= 1'b0;
    end
  end

  always_comb begin
    probe_busy = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (probe_id == ID_W'(i)) probe_busy = busy_q[i];
  end

  // R6: a take never lands on an ID that is already in service
  a_r6_no_double_take: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_id == probe_id) |-> !probe_busy);
endmodule

// File: rtl/cpuif_select.sv
module cpuif_select
  import cpuif_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic              en,
  input  logic [PRIO_W-1:0] mask,
  input  logic              busy,
  output logic              eligible,
  output logic              irq_q
);
  logic in_range;

  assign in_range = cand_id < ID_W'(NUM_SRC);
  assign eligible = cand_valid && in_range && en && (cand_prio < mask) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= eligible;
  end

  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_q);
  a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_prio >= mask) |=> !irq_q);
endmodule

// File: rtl/cpu_ack_if.sv
module cpu_ack_if
  import cpuif_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cand_valid,
  input  logic [9:0]  cand_id,
  input  logic [7:0]  cand_prio,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [1:0]  acc_addr,
  input  logic [31:0] acc_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        take_valid,
  output logic [9:0]  take_id,
  output logic        irq_o
);
  localparam int SRC_OK = (NUM_SRC > 0 && NUM_SRC <= MAX_REAL_ID + 1) ? 1 : 0;

  reg_addr_e         addr;
  logic              wr_en, rd_en, ack_rd, take_now, eoi_wr;
  logic              en_q, busy, eligible, irq_q;
  logic [PRIO_W-1:0] mask_q;
  logic [DATA_W-1:0] rd_next;

  assign addr     = reg_addr_e'(acc_addr);
  assign wr_en    = acc_valid && acc_write;
  assign rd_en    = acc_valid && !acc_write;
  assign ack_rd   = rd_en && addr == RA_ACK;
  assign take_now = ack_rd && eligible;
  assign eoi_wr   = wr_en && addr == RA_EOI;

  cpuif_regs u_regs (
    .clk, .rst_n, .wr_en, .addr, .wdata(acc_wdata), .en_q, .mask_q
  );

  cpuif_active #(.NUM_SRC(NUM_SRC)) u_active (
    .clk, .rst_n,
    .set_en(take_now), .set_id(cand_id),
    .clr_en(eoi_wr),   .clr_id(acc_wdata[ID_W-1:0]),
    .probe_id(cand_id), .probe_busy(busy)
  );

  cpuif_select #(.NUM_SRC(NUM_SRC)) u_sel (
    .clk, .rst_n, .cand_valid, .cand_id, .cand_prio,
    .en(en_q), .mask(mask_q), .busy, .eligible, .irq_q
  );

  always_comb begin
    rd_next = '0;
    unique case (addr)
      RA_CTRL: rd_next[0] = en_q;
      RA_MASK: rd_next[PRIO_W-1:0] = mask_q;
      RA_ACK:  rd_next[ID_W-1:0] = eligible ? cand_id : SPURIOUS_ID;
      RA_EOI:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      take_valid <= 1'b0;
      take_id    <= '0;
    end else begin
      rd_valid   <= rd_en;
      take_valid <= take_now;
      if (rd_en)    rd_data <= rd_next;
      if (take_now) take_id <= cand_id;
    end
  end

  assign irq_o = irq_q;

  a_r2_param_ok: assert final (SRC_OK == 1);
  a_r6_take_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> (rd_valid && rd_data[ID_W-1:0] == take_id));
  a_r3_spurious_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_data[ID_W-1:0] == SPURIOUS_ID) |-> !take_valid);
  a_r2_real_id: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid |-> take_id <= ID_W'(MAX_REAL_ID));
endmodule

// File: tb/sim_cpu_ack_if.sv
module sim_cpu_ack_if;
  localparam int NSRC = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [1:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid, take_valid, irq_o;
  logic [31:0] rd_data;
  logic [9:0]  take_id;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  bit          m_act [NSRC];
  bit          m_en;
  int          m_mask;
  bit          e_irq, e_rv, e_tv;
  int          e_rd, e_tid, e_addr;

  always #10 clk = ~clk;

  cpu_ack_if #(.NUM_SRC(NSRC)) u0 (
    .clk, .rst_n, .cand_valid, .cand_id, .cand_prio,
    .acc_valid, .acc_write, .acc_addr, .acc_wdata,
    .rd_valid, .rd_data, .take_valid, .take_id, .irq_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    bit elig;
    if (!rst_n) begin
      foreach (m_act[i]) m_act[i] = 0;
      m_en = 0; m_mask = 0;
      e_irq = 0; e_rv = 0; e_tv = 0;
    end else begin
      elig = cand_valid && m_en && cand_id < NSRC && int'(cand_prio) < m_mask
             && !m_act[cand_id];
      e_irq = elig;
      e_rv = acc_valid && !acc_write;
      e_tv = 0;
      e_addr = acc_addr;
      if (e_rv) begin
        case (acc_addr)
          2'd0: e_rd = m_en;
          2'd1: e_rd = m_mask;
          2'd2: if (elig) begin
                  e_rd = cand_id; e_tv = 1; e_tid = cand_id; m_act[cand_id] = 1;
                end else e_rd = 1023;
          default: e_rd = 0;
        endcase
      end
      if (acc_valid && acc_write) begin
        case (acc_addr)
          2'd0: m_en = acc_wdata[0];
          2'd1: m_mask = acc_wdata[7:0];
          2'd3: if (acc_wdata[9:0] < NSRC) m_act[acc_wdata[9:0]] = 0;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check(irq_o == e_irq, "R4 R5 R9 irq", irq_o, e_irq);
      check(rd_valid == e_rv, "R2 R10 rd_valid", rd_valid, e_rv);
      check(take_valid == e_tv, "R6 take_valid", take_valid, e_tv);
      if (e_tv) check(take_id == e_tid, "R6 take_id", take_id, e_tid);
      if (e_rv && rd_valid) begin
        if (e_addr == 2 && e_rd == 1023)
          check(rd_data == 32'(e_rd), "R3 spurious", rd_data, e_rd);
        else if (e_addr == 2)
          check(rd_data == 32'(e_rd), "R2 ack id", rd_data, e_rd);
        else
          check(rd_data == 32'(e_rd), "R10 readback", rd_data, e_rd);
      end
    end
  end

  task automatic acc(input bit w, input int a, input int d);
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_addr = 2'(a); acc_wdata = 32'(d);
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic cand(input bit v, input int id, input int pr);
    @(negedge clk);
    cand_valid = v; cand_id = 10'(id); cand_prio = 8'(pr);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    check(irq_o == 0 && rd_valid == 0 && take_valid == 0, "R1 reset outputs", irq_o, 0);
    @(negedge clk); rst_n = 1;
    acc(0, 0, 0);
    check(rd_data == 0, "R1 enable after reset", rd_data, 0);
    acc(0, 1, 0);
    check(rd_data == 0, "R1 mask after reset", rd_data, 0);
    cand(1, 40, 8'hA0); idle(2);
    check(irq_o == 0, "R1 nothing passes zero mask", irq_o, 0);

    acc(1, 1, 32'hF0); acc(1, 0, 1); idle(2);
    acc(0, 0, 0); acc(0, 1, 0); acc(0, 3, 0);
    acc(0, 2, 0);            // take 40
    idle(2);
    acc(0, 2, 0);            // in service -> spurious
    acc(1, 3, 5); idle(2);   // not in service
    check(irq_o == 0, "R8 bogus eoi ignored", irq_o, 0);
    acc(1, 3, 40); idle(2);
    check(irq_o == 1, "R7 eoi reoffers", irq_o, 1);
    acc(0, 2, 0); acc(1, 3, 40);

    cand(1, 12, 8'hF0); idle(2);
    cand(1, 12, 8'hEF); idle(2);
    acc(1, 0, 0); idle(2);
    acc(0, 2, 0);
    acc(1, 0, 1); idle(2);
    cand(0, 12, 8'h10); idle(2); acc(0, 2, 0);
    cand(1, 63, 8'h00); acc(0, 2, 0);
    cand(1, 64, 8'h00); idle(2); acc(0, 2, 0);
    cand(1, 3, 8'h20); acc(0, 2, 0);
    cand(1, 7, 8'h30); acc(0, 2, 0);
    cand(1, 3, 8'h20); idle(2);
    acc(1, 3, 3); idle(2);
    check(irq_o == 1, "R7 eoi id 3", irq_o, 1);
    acc(1, 3, 7); acc(1, 3, 63); acc(0, 2, 0);
    cand(0, 0, 0); idle(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule